// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block drives and samples a bank of general-purpose pins and turns pin activity into one combined interrupt request. Every pin has a direction bit and an output bit. Software changes output bits by whole-word writes or by bit-wise set and clear writes, so it needs no read-modify-write. Pin inputs pass through a two-flop synchronizer. The synchronized value can be read back, and it feeds a separate event detector for each pin.

Each detector is configured by three bits held in three separate per-pin registers. The method bit picks edge or level detection. The both-edges bit makes an edge detector fire on any transition. The type bit picks rising or falling for a single edge, and active-high or active-low for a level. Edge events stay latched until software acknowledges them with a write-one-to-clear. Level events follow the qualified pin level. Raw status is readable. Masked status is raw status qualified by an enable register and a mask register, and the OR of the masked bits drives the interrupt line.

The register port is a plain single-cycle port. A write takes effect at the clock edge where the request is valid. Read data is combinational from the address. The asynchronous reset is released synchronously inside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero and `irq_out` is low.
- R2: The word at offset 0x00 holds the output value driven on `pin_out`. The word at offset 0x08 holds the direction, driven on `pin_oe` (1 = output). Both are read/write.
- R3: A write to offset 0x10 sets the output bits where the write data is 1. A write to offset 0x14 clears them. Bits written 0 are unchanged, and both offsets read as zero.
- R4: Offset 0x04 returns the pin levels through a two-stage synchronizer. A pin change made between two clock edges is not visible after the first following edge and is visible after the second.
- R5: With method bit (offset 0x34) 0 and both-edges bit (offset 0x38) 0, the type bit (offset 0x3C) selects rising (0) or falling (1) edge detection. A detected edge latches the status bit until it is acknowledged.
- R6: With method bit 0 and both-edges bit 1, any transition latches the status bit, and the type bit has no effect.
- R7: With method bit 1, the status bit follows the synchronized level: high-active for type 0, low-active for type 1. Acknowledging it while the level is still active leaves it set.
- R8: Writing ones to offset 0x30 clears the latched edge status bits at those positions. Bits written 0 keep their state.
- R9: Offset 0x28 reads raw status AND enable (offset 0x20) AND NOT mask (offset 0x2C). `irq_out` is high exactly when any of those bits is set.
- R10: If an edge event on a pin is detected in the same cycle that an acknowledge of that pin is written, the status bit stays set.
- R11: Offset 0x24 returns the raw per-pin status, whether or not the pin is enabled or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An edge event and a software acknowledge of the same pin can land in the same clock cycle. The bench sets up a latched both-edges status and then toggles the pins. It times the acknowledge write so that it is sampled on the same edge where the synchronized transition reaches the detector. It expects the raw status to stay set. A plain acknowledge with no event is then expected to clear it. The trigger behaviour is swept across all eight method/both/type combinations, spread so that every pin runs each combination in turn. The expected status for each pin is computed arithmetically from its configuration and its previous and current levels.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 8;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_INPUT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_IACK  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_METH  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 8'h3C;

  // Per-pin trigger configuration
  typedef struct packed {
    logic meth;  // 0 = edge, 1 = level
    logic both;  // edge mode: 1 = any transition
    logic typ;   // edge: 0 rising / 1 falling; level: 0 high / 1 low
  } trig_cfg_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_ns = stg_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= raw_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl      = stg_q[STAGES-1];
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cur,
  input  logic      prev,
  input  trig_cfg_t cfg,
  input  logic      ack,
  output logic      flag
);
  logic hit;
  logic flag_d;

  always_comb begin
    hit    = 1'b0;
    flag_d = flag;
    if (cfg.meth) begin
      flag_d = cfg.typ ? ~cur : cur;
    end else begin
      if (cfg.both) hit = cur ^ prev;
      else          hit = cfg.typ ? (prev & ~cur) : (cur & ~prev);
      // a new event outranks an acknowledge in the same cycle
      flag_d = hit | (flag & ~ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam int SYNC_STAGES = 2;

  logic rst_ns;
  logic bus_we;

  logic [NUM_PINS-1:0] dout_q, dout_d;
  logic [NUM_PINS-1:0] dir_q,  dir_d;
  logic [NUM_PINS-1:0] en_q,   en_d;
  logic [NUM_PINS-1:0] mask_q, mask_d;
  logic [NUM_PINS-1:0] meth_q, meth_d;
  logic [NUM_PINS-1:0] both_q, both_d;
  logic [NUM_PINS-1:0] typ_q,  typ_d;
  logic [NUM_PINS-1:0] irq_ack;
  logic [NUM_PINS-1:0] lvl, lvl_prev;
  logic [NUM_PINS-1:0] raw_q;
  logic [NUM_PINS-1:0] msk_stat;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_ns),
    .raw_in   (pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  assign bus_we = bus_valid & bus_write;

  // register next-state
  always_comb begin
    dout_d  = dout_q;
    dir_d   = dir_q;
    en_d    = en_q;
    mask_d  = mask_q;
    meth_d  = meth_q;
    both_d  = both_q;
    typ_d   = typ_q;
    irq_ack = '0;
    if (bus_we) begin
      unique case (bus_addr)
        OFS_DATA:  dout_d  = bus_wdata;
        OFS_SET:   dout_d  = dout_q | bus_wdata;
        OFS_CLR:   dout_d  = dout_q & ~bus_wdata;
        OFS_DIR:   dir_d   = bus_wdata;
        OFS_IEN:   en_d    = bus_wdata;
        OFS_IMASK: mask_d  = bus_wdata;
        OFS_IACK:  irq_ack = bus_wdata;
        OFS_METH:  meth_d  = bus_wdata;
        OFS_BOTH:  both_d  = bus_wdata;
        OFS_TYPE:  typ_d   = bus_wdata;
        default:   ;
      endcase
    end
  end

  // register state
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dout_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
      meth_q <= '0;
      both_q <= '0;
      typ_q  <= '0;
    end else if (bus_we) begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      en_q   <= en_d;
      mask_q <= mask_d;
      meth_q <= meth_d;
      both_q <= both_d;
      typ_q  <= typ_d;
    end
  end

  // one detector per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_cfg_t cfg_p;
    assign cfg_p.meth = meth_q[p];
    assign cfg_p.both = both_q[p];
    assign cfg_p.typ  = typ_q[p];

    gpio_pin_detect u_det (
      .clk   (clk),
      .rst_n (rst_ns),
      .cur   (lvl[p]),
      .prev  (lvl_prev[p]),
      .cfg   (cfg_p),
      .ack   (irq_ack[p]),
      .flag  (raw_q[p])
    );
  end

  assign msk_stat = raw_q & en_q & ~mask_q;
  assign irq_out  = |msk_stat;
  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;

  // read mux
  always_comb begin
    unique case (bus_addr)
      OFS_DATA:  bus_rdata = dout_q;
      OFS_INPUT: bus_rdata = lvl;
      OFS_DIR:   bus_rdata = dir_q;
      OFS_IEN:   bus_rdata = en_q;
      OFS_RAW:   bus_rdata = raw_q;
      OFS_MSTAT: bus_rdata = msk_stat;
      OFS_IMASK: bus_rdata = mask_q;
      OFS_METH:  bus_rdata = meth_q;
      OFS_BOTH:  bus_rdata = both_q;
      OFS_TYPE:  bus_rdata = typ_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_ns,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] raw_q,
  input logic [NUM_PINS-1:0] msk_stat,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] meth_q,
  input logic [NUM_PINS-1:0] irq_ack,
  input logic                irq_out
);
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !$past(bus_valid && bus_write) |-> $stable(pin_oe)); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !$past(bus_valid && bus_write) |-> $stable(pin_out)); // R3

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_ns)
    (($past(raw_q) & ~$past(meth_q) & ~$past(irq_ack)) & ~raw_q) == '0); // R5

  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_ns)
    (msk_stat & ~raw_q) == '0); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_out |-> (en_q != '0)); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .raw_q     (raw_q),
  .msk_stat  (msk_stat),
  .en_q      (en_q),
  .meth_q    (meth_q),
  .irq_ack   (irq_ack),
  .irq_out   (irq_out)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int N = 32;

  logic         clk;
  logic         rst_n;
  logic         bus_valid, bus_write;
  logic [7:0]   bus_addr;
  logic [N-1:0] bus_wdata, bus_rdata;
  logic [N-1:0] pin_in, pin_out, pin_oe;
  logic         irq_out;

  int total = 0;
  int bad   = 0;

  gpio_irq_ctrl #(.NUM_PINS(N)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // called at a negedge; the write is sampled at the next posedge
  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic exp_stat(input logic m, input logic b, input logic t,
                                    input logic pv, input logic cv);
    if (m)      return t ? ~cv : cv;
    else if (b) return pv ^ cv;
    else        return t ? (pv & ~cv) : (~pv & cv);
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] m_v, b_v, t_v, e_v, en_v, mk_v;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd(8'h00, v); chk("R1 data", v, '0);
    rd(8'h08, v); chk("R1 dir", v, '0);
    rd(8'h20, v); chk("R1 enable", v, '0);
    rd(8'h24, v); chk("R1 raw", v, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 irq", {{N-1{1'b0}}, irq_out}, '0);

    // R2: data and direction
    wr(8'h08, 32'hF0F0_1234);
    rd(8'h08, v); chk("R2 dir read", v, 32'hF0F0_1234);
    chk("R2 pin_oe", pin_oe, 32'hF0F0_1234);
    wr(8'h00, 32'h0000_0000);
    chk("R2 pin_out zero", pin_out, '0);

    // R3: set / clear
    wr(8'h10, 32'h0000_0011);
    wr(8'h10, 32'h8000_0100);
    chk("R3 set", pin_out, 32'h8000_0111);
    wr(8'h14, 32'h0000_0001);
    chk("R3 clr", pin_out, 32'h8000_0110);
    rd(8'h00, v); chk("R3 data read", v, 32'h8000_0110);
    rd(8'h10, v); chk("R3 set reads 0", v, '0);
    rd(8'h14, v); chk("R3 clr reads 0", v, '0);

    // R4: two-stage input synchronizer
    pin_in = 32'h5A5A_0F0F;
    @(negedge clk);
    rd(8'h04, v); chk("R4 not yet", v, '0);
    @(negedge clk);
    rd(8'h04, v); chk("R4 visible", v, 32'h5A5A_0F0F);
    pin_in = '0;
    idle(4);
    wr(8'h30, '1);

    // sweep: pin p uses combo (c+p)%8 = {meth,both,typ}  R5 R6 R7 R9 R11
    en_v = 32'hFFFF_00FF;
    mk_v = 32'h0F00_0F00;
    wr(8'h20, en_v);
    wr(8'h2C, mk_v);
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < N; p++) begin
        int k;
        k = (c + p) % 8;
        m_v[p] = k[2]; b_v[p] = k[1]; t_v[p] = k[0];
      end
      wr(8'h34, m_v); wr(8'h38, b_v); wr(8'h3C, t_v);
      pin_in = '0;
      idle(4);
      wr(8'h30, '1);
      for (int p = 0; p < N; p++) e_v[p] = exp_stat(m_v[p], b_v[p], t_v[p], 1'b0, 1'b0);
      rd(8'h24, v); chk("R7 raw idle low", v, e_v);

      pin_in = '1;
      idle(4);
      for (int p = 0; p < N; p++) e_v[p] = exp_stat(m_v[p], b_v[p], t_v[p], 1'b0, 1'b1);
      rd(8'h24, v); chk("R5 R6 R11 raw after rise", v, e_v);
      rd(8'h28, v); chk("R9 masked after rise", v, e_v & en_v & ~mk_v);
      chk("R9 irq after rise", {{N-1{1'b0}}, irq_out},
          {{N-1{1'b0}}, |(e_v & en_v & ~mk_v)});

      wr(8'h30, '1);
      for (int p = 0; p < N; p++) e_v[p] = m_v[p] ? ~t_v[p] ^ 1'b0 & 1'b1 : 1'b0;
      for (int p = 0; p < N; p++) e_v[p] = m_v[p] ? exp_stat(1'b1, 1'b0, t_v[p], 1'b1, 1'b1) : 1'b0;
      rd(8'h24, v); chk("R7 R8 raw after ack", v, e_v);

      pin_in = '0;
      idle(4);
      for (int p = 0; p < N; p++) e_v[p] = exp_stat(m_v[p], b_v[p], t_v[p], 1'b1, 1'b0);
      rd(8'h24, v); chk("R5 R6 R7 raw after fall", v, e_v);
      rd(8'h28, v); chk("R9 masked after fall", v, e_v & en_v & ~mk_v);
    end

    // R8: partial acknowledge
    wr(8'h34, '0); wr(8'h38, '0); wr(8'h3C, '0);
    idle(2);
    wr(8'h30, '1);
    pin_in = '1;
    idle(4);
    wr(8'h30, 32'h0000_FFFF);
    rd(8'h24, v); chk("R8 partial ack", v, 32'hFFFF_0000);
    wr(8'h30, '1);
    rd(8'h24, v); chk("R8 full ack", v, '0);

    // R10: edge event and acknowledge in the same cycle
    wr(8'h38, '1);
    pin_in = '0;
    idle(4);
    rd(8'h24, v); chk("R10 pre latched", v, '1);
    pin_in = '1;
    @(negedge clk);
    @(negedge clk);
    wr(8'h30, '1);
    rd(8'h24, v); chk("R10 event wins", v, '1);
    wr(8'h30, '1);
    rd(8'h24, v); chk("R10 plain ack clears", v, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule